// File: doc/BRIEF.md
# Memory Controller Error Flag Unit

This block gathers four error events from a nonvolatile memory controller into sticky flags: a corrected bit error, an uncorrectable bit error, an access-time violation and a write-protect violation. Each event arrives as a single-cycle pulse. Every flag can raise a non-maskable interrupt request when its own enable is set. The uncorrectable flag can also request a system reset.

Software clears flags in two ways. It can write zero to a flag bit, or it can read a vector word. The vector names the highest-priority pending flag, and reading it clears that flag only.

The block also holds the memory wait-state field. An access-time violation forces this field to its maximum value. While the violation flag stays set, the field is locked and every memory write is refused, whatever the write-protect setting.

Top module: `memerr_flags`

## Requirements
- R1: After reset, `flags_o` is 0, `ws_o` is 0, `vec_o` is 0, and `nmi_o` and `rst_req_o` are low.
- R2: Each flag sets one cycle after its event and stays set until it is cleared. The bit positions in `flags_o` are: bit 0 corrected error, bit 1 uncorrectable error, bit 2 access-time violation, bit 3 write-protect violation. The write-protect event is `wr_attempt_i` high while `wp_en_i` is high; a write attempt with `wp_en_i` low sets nothing.
- R3: A cycle with `flag_wr_i` high clears every flag whose `flag_wdata_i` bit is 0. A 1 in a data bit leaves that flag unchanged.
- R4: If a set event and a clear (a software write or a vector read) hit the same flag in the same cycle, the flag ends up set.
- R5: `vec_o` reads 2 when the write-protect flag is the highest pending flag, 4 for access-time, 6 for uncorrectable, 8 for corrected, and 0 when no flag is pending. Priority runs in that order, write-protect highest.
- R6: A cycle with `vec_rd_i` high clears only the flag that `vec_o` names in that cycle; all other flags keep their values.
- R7: An access-time event loads `ws_o` with its maximum value (4'hF) on the next cycle. This overrides a wait-state write made in the same cycle.
- R8: A `ws_wr_i` write loads `ws_o` on the next cycle when the access-time flag is clear. It is ignored while the access-time flag is set.
- R9: `wr_grant_o` is high in a cycle exactly when `wr_attempt_i` is high, `wp_en_i` is low and the access-time flag is clear.
- R10: `nmi_o` is high whenever at least one pending flag has its interrupt enable set, and low otherwise.
- R11: `rst_req_o` is high for exactly one cycle, the cycle in which the uncorrectable flag goes from 0 to 1 while `ue_rst_en_i` is high. A new uncorrectable event while the flag is already set produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous brown-out-class reset |
| wr_attempt_i | input | 1 | A memory write is being attempted this cycle |
| wp_en_i | input | 1 | Write protection enabled |
| acc_viol_i | input | 1 | Access-time violation pulse |
| ue_det_i | input | 1 | Uncorrectable bit error pulse |
| ce_det_i | input | 1 | Corrected bit error pulse |
| ie_i | input | 4 | Interrupt enables, same bit order as flags_o |
| ue_rst_en_i | input | 1 | Uncorrectable error requests a system reset |
| flag_wr_i | input | 1 | Software write strobe for the flag register |
| flag_wdata_i | input | 4 | Flag write data; a 0 clears, a 1 leaves unchanged |
| vec_rd_i | input | 1 | Vector word read strobe |
| ws_wr_i | input | 1 | Wait-state field write strobe |
| ws_wdata_i | input | 4 | Wait-state write data |
| flags_o | output | 4 | Sticky flags |
| vec_o | output | 8 | Vector word for the highest pending flag |
| ws_o | output | 4 | Wait-state field |
| wr_grant_o | output | 1 | Memory write allowed this cycle |
| nmi_o | output | 1 | Non-maskable interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench makes a set event and a zero-write hit the same flag in one cycle. A design that lets the clear win would lose an error report. It reads the vector word with all four flags pending and steps down the chain one read at a time. A design that cleared every flag on a read, or cleared the wrong flag, would skip vector values. It tries to rewrite the wait-state field while the access-time flag is set and requests a write with protection off. A design without the lock would accept the new wait-state value and grant the write. It also raises the uncorrectable event a second time while its flag is already set. A design that pulsed the reset request on every event, and not only on the flag's rising edge, would request a second reset.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
    // Flag indices; a higher index has higher vector priority
    localparam int NFLAG   = 4;
    localparam int FLG_CE  = 0;
    localparam int FLG_UE  = 1;
    localparam int FLG_ACC = 2;
    localparam int FLG_WP  = 3;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic             rst_req;
    } flag_state_t;
endpackage

// File: rtl/memerr_prio.sv
module memerr_prio #(
    parameter int N     = 4,
    parameter int VEC_W = 8
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     sel_o,
    output logic [VEC_W-1:0] vec_o
);
    // Ascending scan: the last (highest) pending index wins
    always_comb begin
        sel_o = '0;
        vec_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) begin
                sel_o    = '0;
                sel_o[i] = 1'b1;
                vec_o    = VEC_W'(2 * (N - i));
            end
        end
    end
endmodule

// File: rtl/memerr_waitcfg.sv
module memerr_waitcfg #(
    parameter int            WS_W     = 4,
    parameter logic [WS_W-1:0] WS_RESET = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            force_i,
    input  logic            lock_i,
    input  logic            wr_i,
    input  logic [WS_W-1:0] wdata_i,
    output logic [WS_W-1:0] ws_o
);
    localparam logic [WS_W-1:0] WS_MAX = '1;

    logic [WS_W-1:0] ws_d, ws_q;

    always_comb begin
        ws_d = ws_q;
        if (force_i)
            ws_d = WS_MAX;
        else if (wr_i && !lock_i)
            ws_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ws_q <= WS_RESET;
        else        ws_q <= ws_d;
    end

    assign ws_o = ws_q;

    // R8
    ws_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !force_i) |=> $stable(ws_q));
    // R7
    ws_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> (ws_q == WS_MAX));
endmodule

// File: rtl/memerr_flags.sv
module memerr_flags
    import memerr_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int WS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_attempt_i,
    input  logic             wp_en_i,
    input  logic             acc_viol_i,
    input  logic             ue_det_i,
    input  logic             ce_det_i,
    input  logic [NFLAG-1:0] ie_i,
    input  logic             ue_rst_en_i,
    input  logic             flag_wr_i,
    input  logic [NFLAG-1:0] flag_wdata_i,
    input  logic             vec_rd_i,
    input  logic             ws_wr_i,
    input  logic [WS_W-1:0]  ws_wdata_i,
    output logic [NFLAG-1:0] flags_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [WS_W-1:0]  ws_o,
    output logic             wr_grant_o,
    output logic             nmi_o,
    output logic             rst_req_o
);
    flag_state_t      st_d, st_q;
    logic [NFLAG-1:0] ev, clr, top_sel;

    memerr_prio #(.N(NFLAG), .VEC_W(VEC_W)) u_prio (
        .req_i (st_q.flags),
        .sel_o (top_sel),
        .vec_o (vec_o)
    );

    memerr_waitcfg #(.WS_W(WS_W)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .force_i (acc_viol_i),
        .lock_i  (st_q.flags[FLG_ACC]),
        .wr_i    (ws_wr_i),
        .wdata_i (ws_wdata_i),
        .ws_o    (ws_o)
    );

    always_comb begin
        ev          = '0;
        ev[FLG_CE]  = ce_det_i;
        ev[FLG_UE]  = ue_det_i;
        ev[FLG_ACC] = acc_viol_i;
        ev[FLG_WP]  = wr_attempt_i && wp_en_i;

        clr = '0;
        if (flag_wr_i) clr = clr | ~flag_wdata_i;
        if (vec_rd_i)  clr = clr | top_sel;

        st_d.flags   = (st_q.flags & ~clr) | ev;
        st_d.rst_req = st_d.flags[FLG_UE] && !st_q.flags[FLG_UE] && ue_rst_en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o    = st_q.flags;
    assign rst_req_o  = st_q.rst_req;
    assign nmi_o      = |(st_q.flags & ie_i);
    assign wr_grant_o = wr_attempt_i && !wp_en_i && !st_q.flags[FLG_ACC];

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag_chk
        // R2
        flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.flags[k]) |-> $past(ev[k]));
        // R4
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev[k] |=> st_q.flags[k]);
    end

    // R11
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    // R5
    vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags_o) == (vec_o != '0));
    // R6
    vec_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(top_sel));
    // R9
    grant_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FLG_ACC] |-> !wr_grant_o);
endmodule

// File: tb/memerr_flags_test.sv
module memerr_flags_test;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_attempt_i = 0, wp_en_i = 0, acc_viol_i = 0, ue_det_i = 0, ce_det_i = 0;
    logic [3:0] ie_i = '0;
    logic       ue_rst_en_i = 0, flag_wr_i = 0, vec_rd_i = 0, ws_wr_i = 0;
    logic [3:0] flag_wdata_i = '0, ws_wdata_i = '0;
    logic [3:0] flags_o, ws_o;
    logic [7:0] vec_o;
    logic       wr_grant_o, nmi_o, rst_req_o;
    int n_chk = 0, n_fail = 0;

    memerr_flags uut (.*);

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // advance to next negedge, then drop all strobes
    task automatic tick();
        @(negedge clk);
        wr_attempt_i = 0; acc_viol_i = 0; ue_det_i = 0; ce_det_i = 0;
        flag_wr_i = 0; vec_rd_i = 0; ws_wr_i = 0;
    endtask

    task automatic clear_all();
        flag_wr_i = 1; flag_wdata_i = 4'b0000; tick();
    endtask

    task automatic t_reset();
        check("R1 flags", flags_o, 0);
        check("R1 ws", ws_o, 0);
        check("R1 vec", vec_o, 0);
        check("R1 nmi", nmi_o, 0);
        check("R1 rst_req", rst_req_o, 0);
    endtask

    task automatic t_set_sticky();
        ce_det_i = 1; tick();
        check("R2 ce set", flags_o, 4'b0001);
        tick();
        check("R2 sticky", flags_o, 4'b0001);
        wp_en_i = 0; wr_attempt_i = 1; #1;
        check("R9 grant open", wr_grant_o, 1);
        tick();
        check("R2 no wp when unprotected", flags_o, 4'b0001);
        wp_en_i = 1; wr_attempt_i = 1; #1;
        check("R9 grant protected", wr_grant_o, 0);
        tick();
        check("R2 wp set", flags_o, 4'b1001);
        wp_en_i = 0;
        clear_all();
    endtask

    task automatic t_w0c();
        ue_det_i = 1; ce_det_i = 1; tick();
        flag_wr_i = 1; flag_wdata_i = 4'b1110; tick();
        check("R3 clear ce only", flags_o, 4'b0010);
        flag_wr_i = 1; flag_wdata_i = 4'b1111; tick();
        check("R3 write one no effect", flags_o, 4'b0010);
        clear_all();
        check("R3 clear all", flags_o, 0);
    endtask

    task automatic t_setwins();
        ce_det_i = 1; tick();
        ce_det_i = 1; flag_wr_i = 1; flag_wdata_i = 4'b0000; tick();
        check("R4 set beats write", flags_o, 4'b0001);
        wp_en_i = 1; wr_attempt_i = 1; tick();
        wp_en_i = 1; wr_attempt_i = 1; vec_rd_i = 1; tick();
        check("R4 set beats read", flags_o, 4'b1001);
        wp_en_i = 0;
        clear_all();
    endtask

    task automatic t_vector();
        ce_det_i = 1; ue_det_i = 1; acc_viol_i = 1; wp_en_i = 1; wr_attempt_i = 1; tick();
        wp_en_i = 0;
        check("R5 vec wp", vec_o, 2);
        vec_rd_i = 1; tick();
        check("R6 only wp cleared", flags_o, 4'b0111);
        check("R5 vec acc", vec_o, 4);
        vec_rd_i = 1; tick();
        check("R6 only acc cleared", flags_o, 4'b0011);
        check("R5 vec ue", vec_o, 6);
        vec_rd_i = 1; tick();
        check("R5 vec ce", vec_o, 8);
        vec_rd_i = 1; tick();
        check("R5 vec none", vec_o, 0);
        check("R6 all drained", flags_o, 0);
        ue_det_i = 1; tick();
        check("R5 vec ue alone", vec_o, 6);
        clear_all();
    endtask

    task automatic t_wait();
        ws_wr_i = 1; ws_wdata_i = 4'd5; tick();
        check("R8 ws write accepted", ws_o, 5);
        acc_viol_i = 1; ws_wr_i = 1; ws_wdata_i = 4'd2; tick();
        check("R7 ws forced max", ws_o, 15);
        ws_wr_i = 1; ws_wdata_i = 4'd3; tick();
        check("R8 ws locked", ws_o, 15);
        wr_attempt_i = 1; #1;
        check("R9 grant blocked by acc", wr_grant_o, 0);
        tick();
        check("R9 no wp flag from acc block", flags_o, 4'b0100);
        clear_all();
        ws_wr_i = 1; ws_wdata_i = 4'd3; tick();
        check("R8 ws unlocked", ws_o, 3);
    endtask

    task automatic t_nmi();
        ie_i = 4'b1110; ce_det_i = 1; tick();
        check("R10 nmi masked", nmi_o, 0);
        ie_i = 4'b0001; #1;
        check("R10 nmi enabled", nmi_o, 1);
        clear_all();
        check("R10 nmi after clear", nmi_o, 0);
        ie_i = '0;
    endtask

    task automatic t_rst();
        ue_rst_en_i = 1; ue_det_i = 1; tick();
        check("R11 pulse", rst_req_o, 1);
        tick();
        check("R11 pulse ends", rst_req_o, 0);
        ue_det_i = 1; tick();
        check("R11 no repeat", rst_req_o, 0);
        clear_all();
        ue_rst_en_i = 0; ue_det_i = 1; tick();
        check("R11 disabled", rst_req_o, 0);
        clear_all();
    endtask

    initial begin
        #35 rst_n = 1'b1;
        tick();
        t_reset();
        t_set_sticky();
        t_w0c();
        t_setwins();
        t_vector();
        t_wait();
        t_nmi();
        t_rst();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule